// File: doc/BRIEF.md
# Paired-Page Translation Lookup Buffer

This block translates a 32-bit virtual address into a physical address. It uses a small, fully associative table of translation entries. Each entry describes two neighbouring virtual pages of equal size, an even page and an odd page. Each half has its own frame number, valid bit and dirty bit. A per-entry page-size mask widens the pair from the 4 KB minimum to larger sizes. An entry applies to the requesting address space when its address-space tag matches the current 8-bit identifier, or when the entry is marked global.

The lookup is purely combinational from the current table contents. The requester presents an address, an identifier and a load/store flag, and reads back a 2-bit outcome, a physical address and a store-permission flag in the same cycle. A one-cycle load port writes a whole entry at a chosen index on a rising clock edge. If more than one entry claims an address, the entry with the smallest index decides the outcome.

Top module: `pair_tlb_lookup`

## Requirements
- R1: After reset, every entry reads as all-zero: tag 0, identifier 0, not global, both halves not valid. A lookup of an address below 0x2000 with identifier 0 therefore returns outcome 2 (invalid). Any other address, or any other identifier, returns outcome 1 (miss).
- R2: When `ld_en_i` is high at a rising edge, the entry at `ld_idx_i` is fully replaced by the load fields. Lookups see the new entry as soon as that edge has passed.
- R3: An entry claims an address only if its global bit is set or its identifier equals `lk_asid_i`, and its stored pair tag equals the address once both have their effective-mask bits cleared.
- R4: The effective mask has ones in bits 12..0, and holds `ld_mask_i` in bits 13 and up. The mask field is a run of low-order ones. Mask 0 gives a pair of 4 KB pages, and mask 2'b11 gives a pair of 16 KB pages.
- R5: The highest set bit of the effective mask selects the half: bit 12 for 4 KB pages, bit 14 for 16 KB pages. A 0 in that address bit selects the even half, and a 1 selects the odd half.
- R6: If the selected half is not valid, the outcome is 2 (invalid).
- R7: A store (`lk_store_i`=1) to a valid half whose dirty bit is clear gives outcome 3 (modify fault). A load from such a half gives outcome 0 with `lk_wr_ok_o`=0.
- R8: On outcome 0 (hit), `lk_pa_o` equals {frame number, 12 zero bits} ORed with the address bits under the effective mask shifted right by one. `lk_wr_ok_o` equals the selected half's dirty bit.
- R9: When no entry claims the address, the outcome is 1 (miss).
- R10: If several entries claim an address, only the lowest-indexed one decides the outcome, even when its selected half is not valid.
- R11: For any outcome other than 0, `lk_pa_o` is 0 and `lk_wr_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry table |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_va_i | input | 32 | Virtual address to translate |
| lk_asid_i | input | 8 | Current address-space identifier |
| lk_store_i | input | 1 | 1 = store access, 0 = load access |
| lk_pa_o | output | 32 | Translated physical address |
| lk_wr_ok_o | output | 1 | Store permitted for the translated page |
| lk_res_o | output | 2 | Outcome: 0 hit, 1 miss, 2 invalid, 3 modify fault |
| ld_en_i | input | 1 | Write one entry this cycle |
| ld_idx_i | input | 4 | Entry index to write |
| ld_vpn2_i | input | 19 | Pair tag, virtual address bits 31..13 |
| ld_mask_i | input | 16 | Page-size mask, applied at bits 28..13 |
| ld_asid_i | input | 8 | Entry address-space identifier |
| ld_global_i | input | 1 | Entry ignores the identifier |
| ld_pfn_even_i | input | 20 | Frame number of the even half |
| ld_pfn_odd_i | input | 20 | Frame number of the odd half |
| ld_valid_even_i | input | 1 | Even half valid |
| ld_dirty_even_i | input | 1 | Even half writable |
| ld_valid_odd_i | input | 1 | Odd half valid |
| ld_dirty_odd_i | input | 1 | Odd half writable |

## Verification
The bench builds the block with its default parameters: 16 entries, a 32-bit address, an 8-bit identifier and a 16-bit mask field. This leaves enough free entries to hold a 4 KB pair, a 16 KB pair, a global pair and a duplicate of the 4 KB pair all at once. With that layout one table of vectors reaches every outcome code. It covers both halves of each page size, the first address past each pair, and an identifier mismatch. It also covers the lowest-index rule against a later duplicate, including the case where the winning entry's half is invalid.

// File: rtl/tlbx_pkg.sv
`timescale 1ns/1ps
package tlbx_pkg;
  typedef enum logic [1:0] {
    RES_HIT     = 2'd0,
    RES_MISS    = 2'd1,
    RES_INVALID = 2'd2,
    RES_MODIFY  = 2'd3
  } lk_res_e;
endpackage

// File: rtl/tlbx_rst_sync.sv
`timescale 1ns/1ps
module tlbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/tlbx_entry_store.sv
`timescale 1ns/1ps
module tlbx_entry_store #(
  parameter int ENTRIES = 16,
  parameter int ENT_W   = 89,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [ENT_W-1:0] ld_word_i,
  output logic [ENT_W-1:0] ent_o [ENTRIES]
);
  logic [ENT_W-1:0] ent_q [ENTRIES];
  logic [ENT_W-1:0] ent_d [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel_en;
    assign sel_en = ld_en_i && (ld_idx_i == IDX_W'(g));

    always_comb begin
      ent_d[g] = ent_q[g];
      if (sel_en) ent_d[g] = ld_word_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else        ent_q[g] <= ent_d[g];
    end

    assign ent_o[g] = ent_q[g];
  end

  // R2: a load lands whole at the addressed slot
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en_i |=> (ent_q[$past(ld_idx_i)] == $past(ld_word_i)));
endmodule

// File: rtl/tlbx_match_row.sv
`timescale 1ns/1ps
module tlbx_match_row #(
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int MASK_W   = 16,
  parameter int ID_W     = 8,
  localparam int VPN_W   = VA_W - PG_SHIFT - 1,
  localparam int PFN_W   = VA_W - PG_SHIFT,
  localparam int O_D1    = 0,
  localparam int O_V1    = 1,
  localparam int O_D0    = 2,
  localparam int O_V0    = 3,
  localparam int O_PF1   = 4,
  localparam int O_PF0   = O_PF1 + PFN_W,
  localparam int O_G     = O_PF0 + PFN_W,
  localparam int O_ID    = O_G + 1,
  localparam int O_MK    = O_ID + ID_W,
  localparam int O_VP    = O_MK + MASK_W,
  localparam int ENT_W   = O_VP + VPN_W
) (
  input  logic [ENT_W-1:0] ent_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [ID_W-1:0]  asid_i,
  output logic             hit_o,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [VA_W-1:0]  pa_o
);
  logic [VA_W-1:0]  eff;
  logic [VA_W-1:0]  tag_full;
  logic [VA_W-1:0]  low_mask;
  logic             id_ok;
  logic             odd;
  logic [PFN_W-1:0] pfn_sel;

  always_comb begin
    eff = '0;
    eff[PG_SHIFT:0] = '1;
    eff[PG_SHIFT+MASK_W:PG_SHIFT+1] = ent_i[O_MK +: MASK_W];
    low_mask = eff >> 1;
    tag_full = {ent_i[O_VP +: VPN_W], {(PG_SHIFT+1){1'b0}}};
    id_ok    = ent_i[O_G] || (ent_i[O_ID +: ID_W] == asid_i);
    hit_o    = id_ok && (((va_i ^ tag_full) & ~eff) == '0);
    odd      = |(va_i & eff & ~low_mask);
    pfn_sel  = odd ? ent_i[O_PF1 +: PFN_W] : ent_i[O_PF0 +: PFN_W];
    valid_o  = odd ? ent_i[O_V1] : ent_i[O_V0];
    dirty_o  = odd ? ent_i[O_D1] : ent_i[O_D0];
    pa_o     = {pfn_sel, {PG_SHIFT{1'b0}}} | (va_i & low_mask);
  end
endmodule

// File: rtl/tlbx_select.sv
`timescale 1ns/1ps
module tlbx_select
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ENTRIES-1:0] hit_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] dirty_i,
  input  logic [VA_W-1:0] pa_i [ENTRIES],
  input  logic            store_i,
  output lk_res_e         res_o,
  output logic [VA_W-1:0] pa_o,
  output logic            wr_ok_o
);
  logic [ENTRIES-1:0] grant;
  logic               found;
  logic               v_sel;
  logic               d_sel;
  logic [VA_W-1:0]    pa_sel;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_i[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    v_sel  = 1'b0;
    d_sel  = 1'b0;
    pa_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        v_sel  = valid_i[i];
        d_sel  = dirty_i[i];
        pa_sel = pa_i[i];
      end
    end
  end

  always_comb begin
    if (!found)                res_o = RES_MISS;
    else if (!v_sel)           res_o = RES_INVALID;
    else if (store_i && !d_sel) res_o = RES_MODIFY;
    else                       res_o = RES_HIT;
    pa_o    = (res_o == RES_HIT) ? pa_sel : '0;
    wr_ok_o = (res_o == RES_HIT) && d_sel;
  end

  // R10: at most one entry decides
  assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R10: the deciding entry has no lower-indexed claimant
  assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((hit_i & (grant - 1'b1)) == '0));
  // R9: a miss means nothing claimed the address
  assert_miss_no_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o == RES_MISS) |-> (hit_i == '0));
endmodule

// File: rtl/pair_tlb_lookup.sv
`timescale 1ns/1ps
module pair_tlb_lookup
  import tlbx_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 12,
  parameter int MASK_W   = 16,
  parameter int ID_W     = 8,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W   = VA_W - PG_SHIFT - 1,
  localparam int PFN_W   = VA_W - PG_SHIFT,
  localparam int ENT_W   = 4 + 2*PFN_W + 1 + ID_W + MASK_W + VPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_va_i,
  input  logic [ID_W-1:0]  lk_asid_i,
  input  logic             lk_store_i,
  output logic [VA_W-1:0]  lk_pa_o,
  output logic             lk_wr_ok_o,
  output logic [1:0]       lk_res_o,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [VPN_W-1:0] ld_vpn2_i,
  input  logic [MASK_W-1:0] ld_mask_i,
  input  logic [ID_W-1:0]  ld_asid_i,
  input  logic             ld_global_i,
  input  logic [PFN_W-1:0] ld_pfn_even_i,
  input  logic [PFN_W-1:0] ld_pfn_odd_i,
  input  logic             ld_valid_even_i,
  input  logic             ld_dirty_even_i,
  input  logic             ld_valid_odd_i,
  input  logic             ld_dirty_odd_i
);
  logic               rst_sync_n;
  logic [ENT_W-1:0]   ld_word;
  logic [ENT_W-1:0]   ent [ENTRIES];
  logic [ENTRIES-1:0] hit;
  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] dirty;
  logic [VA_W-1:0]    pa_cand [ENTRIES];
  lk_res_e            res;

  assign ld_word = {ld_vpn2_i, ld_mask_i, ld_asid_i, ld_global_i,
                    ld_pfn_even_i, ld_pfn_odd_i,
                    ld_valid_even_i, ld_dirty_even_i,
                    ld_valid_odd_i, ld_dirty_odd_i};

  tlbx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tlbx_entry_store #(.ENTRIES(ENTRIES), .ENT_W(ENT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ld_en_i   (ld_en_i),
    .ld_idx_i  (ld_idx_i),
    .ld_word_i (ld_word),
    .ent_o     (ent)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    tlbx_match_row #(
      .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .MASK_W(MASK_W), .ID_W(ID_W)
    ) u_row (
      .ent_i   (ent[g]),
      .va_i    (lk_va_i),
      .asid_i  (lk_asid_i),
      .hit_o   (hit[g]),
      .valid_o (valid[g]),
      .dirty_o (dirty[g]),
      .pa_o    (pa_cand[g])
    );
  end

  tlbx_select #(.ENTRIES(ENTRIES), .VA_W(VA_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hit_i   (hit),
    .valid_i (valid),
    .dirty_i (dirty),
    .pa_i    (pa_cand),
    .store_i (lk_store_i),
    .res_o   (res),
    .pa_o    (lk_pa_o),
    .wr_ok_o (lk_wr_ok_o)
  );

  assign lk_res_o = res;

  // R11: non-hit outcomes expose no address and no permission
  assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_res_o != 2'd0) |-> (lk_pa_o == '0 && !lk_wr_ok_o));
  // R7: a modify fault only arises from a store
  assert_modify_on_store_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_res_o == 2'd3) |-> lk_store_i);
  // R8: store permission implies a hit
  assert_perm_implies_hit_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_wr_ok_o |-> (lk_res_o == 2'd0));
endmodule

// File: tb/sim_pair_tlb_lookup.sv
`timescale 1ns/1ps
module sim_pair_tlb_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        lk_store;
  logic [31:0] lk_pa;
  logic        lk_wr_ok;
  logic [1:0]  lk_res;
  logic        ld_en;
  logic [3:0]  ld_idx;
  logic [18:0] ld_vpn2;
  logic [15:0] ld_mask;
  logic [7:0]  ld_asid;
  logic        ld_glb;
  logic [19:0] ld_pf0, ld_pf1;
  logic        ld_v0, ld_d0, ld_v1, ld_d1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pair_tlb_lookup u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_va_i(lk_va), .lk_asid_i(lk_asid), .lk_store_i(lk_store),
    .lk_pa_o(lk_pa), .lk_wr_ok_o(lk_wr_ok), .lk_res_o(lk_res),
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_vpn2_i(ld_vpn2),
    .ld_mask_i(ld_mask), .ld_asid_i(ld_asid), .ld_global_i(ld_glb),
    .ld_pfn_even_i(ld_pf0), .ld_pfn_odd_i(ld_pf1),
    .ld_valid_even_i(ld_v0), .ld_dirty_even_i(ld_d0),
    .ld_valid_odd_i(ld_v1), .ld_dirty_odd_i(ld_d1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: {req[3:0], va[31:0], asid[7:0], store, res[1:0], pa[31:0], wr_ok}
  localparam logic [79:0] VEC [NV] = '{
    {4'd8,  32'h0040_0123, 8'd5,   1'b0, 2'd0, 32'h0010_0123, 1'b1}, // R8 even 4K load
    {4'd10, 32'h0040_0123, 8'd5,   1'b1, 2'd0, 32'h0010_0123, 1'b1}, // R10 dup at idx 3 loses
    {4'd5,  32'h0040_1ABC, 8'd5,   1'b0, 2'd0, 32'h0010_1ABC, 1'b0}, // R5 odd 4K, R7 clean load
    {4'd7,  32'h0040_1ABC, 8'd5,   1'b1, 2'd3, 32'h0000_0000, 1'b0}, // R7 store to clean half
    {4'd3,  32'h0040_0123, 8'd6,   1'b0, 2'd1, 32'h0000_0000, 1'b0}, // R3 identifier mismatch
    {4'd4,  32'h0080_2345, 8'd7,   1'b0, 2'd0, 32'h0020_2345, 1'b1}, // R4 16K even
    {4'd6,  32'h0080_4010, 8'd7,   1'b0, 2'd2, 32'h0000_0000, 1'b0}, // R6 16K odd invalid
    {4'd11, 32'h0080_6FFF, 8'd7,   1'b1, 2'd2, 32'h0000_0000, 1'b0}, // R11 invalid on store
    {4'd3,  32'h1000_0F00, 8'd0,   1'b0, 2'd0, 32'h0030_0F00, 1'b1}, // R3 global even
    {4'd5,  32'h1000_1004, 8'd255, 1'b1, 2'd0, 32'h0030_1004, 1'b1}, // R5 global odd store
    {4'd9,  32'h2000_0000, 8'd5,   1'b0, 2'd1, 32'h0000_0000, 1'b0}, // R9 unmapped
    {4'd4,  32'h0080_8000, 8'd7,   1'b0, 2'd1, 32'h0000_0000, 1'b0}, // R4 first past 16K pair
    {4'd9,  32'h0040_2000, 8'd5,   1'b0, 2'd1, 32'h0000_0000, 1'b0}  // R9 first past 4K pair
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic st);
    @(negedge clk);
    lk_va = va; lk_asid = asid; lk_store = st;
    #1;
  endtask

  task automatic load(input logic [3:0] idx, input logic [31:0] va, input logic [15:0] mk,
                      input logic [7:0] asid, input logic g,
                      input logic [19:0] p0, input logic v0, input logic d0,
                      input logic [19:0] p1, input logic v1, input logic d1);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_vpn2 = va[31:13]; ld_mask = mk;
    ld_asid = asid; ld_glb = g;
    ld_pf0 = p0; ld_v0 = v0; ld_d0 = d0;
    ld_pf1 = p1; ld_v1 = v1; ld_d1 = d1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_vpn2 = '0; ld_mask = '0;
    ld_asid = '0; ld_glb = 1'b0; ld_pf0 = '0; ld_pf1 = '0;
    ld_v0 = 1'b0; ld_d0 = 1'b0; ld_v1 = 1'b0; ld_d1 = 1'b0;
    lk_va = '0; lk_asid = '0; lk_store = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: cleared table
    lookup(32'h0000_0010, 8'd0, 1'b0);
    check("R1 zero-pair res", 32'(lk_res), 32'd2);
    check("R1 zero-pair pa", lk_pa, 32'h0);
    lookup(32'h0000_0010, 8'd3, 1'b0);
    check("R1 other id res", 32'(lk_res), 32'd1);
    lookup(32'h0040_0123, 8'd5, 1'b0);
    check("R1 unloaded res", 32'(lk_res), 32'd1);

    load(4'd0, 32'h0040_0000, 16'h0000, 8'd5, 1'b0, 20'h00100, 1'b1, 1'b1, 20'h00101, 1'b1, 1'b0);
    // R2: visible right after the load edge
    lookup(32'h0040_0123, 8'd5, 1'b0);
    check("R2 visible res", 32'(lk_res), 32'd0);
    load(4'd1, 32'h0080_0000, 16'h0003, 8'd7, 1'b0, 20'h00200, 1'b1, 1'b1, 20'h00210, 1'b0, 1'b1);
    load(4'd2, 32'h1000_0000, 16'h0000, 8'd9, 1'b1, 20'h00300, 1'b1, 1'b1, 20'h00301, 1'b1, 1'b1);
    load(4'd3, 32'h0040_0000, 16'h0000, 8'd5, 1'b0, 20'h00999, 1'b1, 1'b1, 20'h00998, 1'b1, 1'b1);

    for (int k = 0; k < NV; k++) begin
      logic [79:0] v;
      string tag;
      v = VEC[k];
      lookup(v[75:44], v[43:36], v[35]);
      tag = $sformatf("R%0d vec%0d", v[79:76], k);
      check({tag, " res"}, 32'(lk_res), 32'(v[34:33]));
      check({tag, " pa"}, lk_pa, v[32:1]);
      check({tag, " wr_ok"}, 32'(lk_wr_ok), 32'(v[0]));
    end

    // R10: entry 0 still claims but its even half is now invalid
    load(4'd0, 32'h0040_0000, 16'h0000, 8'd5, 1'b0, 20'h00100, 1'b0, 1'b1, 20'h00101, 1'b1, 1'b0);
    lookup(32'h0040_0123, 8'd5, 1'b0);
    check("R10 low invalid wins res", 32'(lk_res), 32'd2);
    check("R11 invalid pa", lk_pa, 32'h0);
    // R2: move entry 0 away, entry 3 now decides
    load(4'd0, 32'h0600_0000, 16'h0000, 8'd5, 1'b0, 20'h00100, 1'b1, 1'b1, 20'h00101, 1'b1, 1'b0);
    lookup(32'h0040_0123, 8'd5, 1'b1);
    check("R2 replaced res", 32'(lk_res), 32'd0);
    check("R2 replaced pa", lk_pa, 32'h0099_9123);
    lookup(32'h0600_1FFF, 8'd5, 1'b0);
    check("R8 relocated odd pa", lk_pa, 32'h0010_1FFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule